// File: doc/BRIEF.md
# NAND Flash Host Bus Bridge

This block lets a processor with a 16-bit register bus drive a raw 8-bit NAND flash device. Software controls the flash pins by writing a mode byte, then moves commands, addresses and data through a single data register. A 16-bit access to that register becomes two back-to-back byte cycles on the flash bus. An 8-bit access becomes a single byte cycle. While the byte cycles run, the bridge holds a wait signal so that the bus master stalls until the transfer is done.

The flash ready/busy line passes through a two-flop synchronizer. The synchronized value appears as a busy flag in a status byte. A busy-to-ready transition latches a ready request in an interrupt status byte. That request drives the interrupt output only while it is unmasked. Software clears pending requests by writing ones to the interrupt status byte. Power-control bits of the mode byte go straight to an output pair, which steers the supply switch of the flash.

A bus request is a one-cycle pulse on `bus_req`, together with the address, the write flag, the access width and the write data. The master must hold `bus_addr` until it has sampled `bus_rdata`. Requests that arrive while `bus_wait` is high are not accepted.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset the mode, interrupt status and interrupt mask bytes read 0x00, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, CLE and ALE are low, `pwr_ctl` is 0 and `irq` is low.
- R2: The mode byte sits at address 4. Bit 4 is chip enable, bit 1 is the address latch and bit 0 is the command latch. `nand_ce_n` is the inverse of bit 4. `nand_cle` and `nand_ale` follow bits 0 and 1 only while bit 4 is set. So 0x95 gives command mode, 0x96 gives address mode, 0x94 gives data mode, and 0x00 gives standby with the chip released.
- R3: `pwr_ctl` equals mode bits [3:2]. Writing 0x0C gives 2'b11 (power on) and writing 0x08 gives 2'b10 (power off).
- R4: An 8-bit write to the data register (address 0, `bus_wide`=0) produces exactly one flash write cycle. That cycle carries `bus_wdata[7:0]`, with CLE and ALE at the levels set by the mode byte.
- R5: A 16-bit write to the data register produces two flash write cycles: `bus_wdata[7:0]` first, then `bus_wdata[15:8]`.
- R6: A 16-bit read of the data register performs two flash read cycles. The first byte lands in `bus_rdata[7:0]` and the second in `bus_rdata[15:8]`. An 8-bit read returns one byte in [7:0] with [15:8] zero.
- R7: Each `nand_we_n` or `nand_re_n` low pulse lasts exactly STROBE_CLKS clock cycles and is followed by one high recovery cycle.
- R8: An accepted data-register access with chip enable set holds `bus_wait` high from the cycle after the request for (STROBE_CLKS+1) cycles per byte.
- R9: With mode bit 4 clear, a data-register access produces no strobe and no wait, and a read of it returns 0.
- R10: Status byte (address 5) bit 7 reads 1 while the synchronized ready/busy input shows busy (`nand_rb` low). It reflects the input after two clock edges.
- R11: A low-to-high transition of the synchronized `nand_rb` sets interrupt status (address 6) bit 0. A high-to-low transition leaves that bit unchanged.
- R12: `irq` is high exactly when interrupt status bit 0 and mask (address 7) bits 0 and 7 are all set. Mask 0x81 enables the interrupt and 0x00 disables it.
- R13: Writing a 1 to an interrupt status bit clears it, so 0x0F clears all pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One-cycle access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| bus_wait | output | 1 | High while flash byte cycles are in progress |
| irq | output | 1 | Ready interrupt request |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Output enable for `nand_io_out` |
| nand_io_in | input | 8 | Byte returned by the flash |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |
| pwr_ctl | output | 2 | Power-control bits from the mode byte |

## Verification
The bench builds the bridge with STROBE_CLKS set to 3 instead of the default 2. A pulse-width or wait-length error therefore shows up as a count mismatch, and cannot hide behind a one- or two-cycle coincidence. At this setting each byte takes four cycles, so a 16-bit access must stall for exactly eight. The ready-request path runs through both edge directions and both mask settings. Standby accesses are checked at the strobe pins, not only through read data.

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge #(
  parameter int STROBE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic        bus_wide,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_wait,
  output logic        irq,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_ce_n,
  output logic        nand_we_n,
  output logic        nand_re_n,
  input  logic        nand_rb,
  output logic [1:0]  pwr_ctl
);
  localparam int CW = $clog2(STROBE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  state_t      state;
  logic [CW-1:0] cnt;
  logic        idx, rd_q, wide_q;
  logic [15:0] wdata_q, data_q;
  logic [7:0]  mode_q, imr_q;
  logic [3:0]  isr_q;
  logic        rb_s1, rb_s2, rb_s3;

  wire go      = bus_req & (state == S_IDLE);
  wire wr_go   = go & bus_wr;
  wire data_go = go & (bus_addr == 3'd0);
  wire ce      = mode_q[4];
  wire rise    = rb_s2 & ~rb_s3;
  wire [3:0] clr = (wr_go && bus_addr == 3'd6) ? bus_wdata[3:0] : 4'h0;

  assign bus_wait    = (state != S_IDLE);
  assign nand_ce_n   = ~ce;
  assign nand_cle    = ce & mode_q[0];
  assign nand_ale    = ce & mode_q[1];
  assign pwr_ctl     = mode_q[3:2];
  assign nand_we_n   = ~(ce & (state == S_LOW) & ~rd_q);
  assign nand_re_n   = ~(ce & (state == S_LOW) & rd_q);
  assign nand_io_oe  = ce & (state != S_IDLE) & ~rd_q;
  assign nand_io_out = idx ? wdata_q[15:8] : wdata_q[7:0];
  assign irq         = imr_q[7] & imr_q[0] & isr_q[0];

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = data_q;
      3'd4:    bus_rdata = {8'h00, mode_q};
      3'd5:    bus_rdata = {8'h00, ~rb_s2, 7'h00};
      3'd6:    bus_rdata = {12'h000, isr_q};
      3'd7:    bus_rdata = {8'h00, imr_q};
      default: bus_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1 <= 1'b1; rb_s2 <= 1'b1; rb_s3 <= 1'b1;
      mode_q <= 8'h00; imr_q <= 8'h00; isr_q <= 4'h0;
    end else begin
      rb_s1 <= nand_rb; rb_s2 <= rb_s1; rb_s3 <= rb_s2;
      isr_q <= (isr_q & ~clr) | {3'b000, rise};
      if (wr_go && bus_addr == 3'd4) mode_q <= bus_wdata[7:0];
      if (wr_go && bus_addr == 3'd7) imr_q  <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; idx <= 1'b0;
      rd_q <= 1'b0; wide_q <= 1'b0;
      wdata_q <= 16'h0; data_q <= 16'h0;
    end else begin
      case (state)
        S_IDLE: if (data_go) begin
          if (!bus_wr) data_q <= 16'h0;
          if (ce) begin
            state   <= S_LOW;
            cnt     <= '0;
            idx     <= 1'b0;
            rd_q    <= ~bus_wr;
            wide_q  <= bus_wide;
            wdata_q <= bus_wdata;
          end
        end
        S_LOW: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= S_HIGH;
            if (rd_q) begin
              if (idx) data_q[15:8] <= nand_io_in;
              else     data_q[7:0]  <= nand_io_in;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (wide_q && !idx) begin
            idx   <= 1'b1;
            state <= S_LOW;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= '0;
    else if (!nand_we_n) we_run <= we_run + 1'b1;
    else we_run <= '0;
  end

  // R7
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (we_run == (CW+1)'(STROBE_CLKS)));
  // R8
  wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wait && bus_addr == 3'd0 && mode_q[4]) |=> bus_wait);
  // R11
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_s2 && !rb_s3) |=> isr_q[0]);
  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (isr_q[0] && imr_q[0] && imr_q[7]));
  // R13
  isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wait && bus_wr && bus_addr == 3'd6 && bus_wdata[0] && !(rb_s2 && !rb_s3))
    |=> !isr_q[0]);
  // R2
  standby_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (!nand_cle && !nand_ale && nand_we_n && nand_re_n));
endmodule

// File: tb/tb_nand_bus_bridge.sv
module tb_nand_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int STROBE = 3;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_wr = 0, bus_wide = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic bus_wait, irq, nand_io_oe, nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n;
  logic [7:0] nand_io_out, nand_io_in = 0;
  logic nand_rb = 1;
  logic [1:0] pwr_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_bridge #(.STROBE_CLKS(STROBE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .irq(irq), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_rb(nand_rb), .pwr_ctl(pwr_ctl));

  int checks = 0, failures = 0;
  bit armed = 0, finished = 0;
  int we_pulses = 0, re_pulses = 0, wait_cycles = 0;
  logic [9:0] exp_q[$];
  logic [7:0] flash_src[$];
  int lowrun = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: each rising write strobe pops one expected {cle,ale,byte}
  always @(posedge nand_we_n) if (armed) begin
    we_pulses++;
    if (exp_q.size() == 0) chk(0, "R4 unexpected write cycle", {22'h0, nand_cle, nand_ale, nand_io_out}, 0);
    else begin
      logic [9:0] e;
      e = exp_q.pop_front();
      chk({nand_cle, nand_ale, nand_io_out} == e, "R4/R5 flash write byte",
          {22'h0, nand_cle, nand_ale, nand_io_out}, {22'h0, e});
    end
  end

  always @(negedge nand_re_n) if (armed) begin
    re_pulses++;
    nand_io_in = (flash_src.size() != 0) ? flash_src.pop_front() : 8'hEE;
  end

  // R7 pulse width observed at the pins
  always @(posedge clk) if (armed) begin
    if (!nand_we_n || !nand_re_n) lowrun <= lowrun + 1;
    else begin
      if (lowrun != 0) chk(lowrun == STROBE, "R7 strobe low width", lowrun, STROBE);
      lowrun <= 0;
    end
  end

  task automatic access(input bit wr, input logic [2:0] a, input bit wide, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = wr; bus_addr = a; bus_wide = wide; bus_wdata = d;
    @(negedge clk);
    bus_req = 0;
    wait_cycles = 0;
    while (bus_wait) begin wait_cycles++; @(negedge clk); end
  endtask

  task automatic wr_data(input bit wide, input logic [15:0] d);
    exp_q.push_back({nand_cle, nand_ale, d[7:0]});
    if (wide) exp_q.push_back({nand_cle, nand_ale, d[15:8]});
    access(1, 3'd0, wide, d);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
    access(0, a, 0, 16'h0);
    v = bus_rdata;
  endtask

  initial begin
    logic [15:0] v;
    int wp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R1 pins after reset",
        {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
    rst_n = 1; armed = 1;
    @(negedge clk);
    chk(!irq && pwr_ctl == 0, "R1 irq/pwr after reset", {irq, pwr_ctl}, 0);
    rd_reg(3'd4, v); chk(v == 0, "R1 mode after reset", v, 0);
    rd_reg(3'd6, v); chk(v == 0, "R1 isr after reset", v, 0);
    rd_reg(3'd7, v); chk(v == 0, "R1 imr after reset", v, 0);

    // R3 power
    access(1, 3'd4, 0, 16'h000C); chk(pwr_ctl == 2'b11, "R3 power on", pwr_ctl, 2'b11);
    access(1, 3'd4, 0, 16'h0008); chk(pwr_ctl == 2'b10, "R3 power off", pwr_ctl, 2'b10);

    // R2 command mode and R4 single command byte
    access(1, 3'd4, 0, 16'h0095);
    chk(!nand_ce_n && nand_cle && !nand_ale, "R2 command mode pins", {nand_ce_n, nand_cle, nand_ale}, 3'b010);
    wp = we_pulses;
    wr_data(0, 16'hAB90);
    chk(we_pulses == wp + 1, "R4 one write cycle", we_pulses - wp, 1);
    chk(wait_cycles == STROBE + 1, "R8 wait for one byte", wait_cycles, STROBE + 1);

    // R2 address mode, R4 address byte
    access(1, 3'd4, 0, 16'h0096);
    chk(!nand_ce_n && !nand_cle && nand_ale, "R2 address mode pins", {nand_ce_n, nand_cle, nand_ale}, 3'b001);
    wr_data(0, 16'h0012);

    // R2 data mode, R5 16-bit write order
    access(1, 3'd4, 0, 16'h0094);
    chk(!nand_ce_n && !nand_cle && !nand_ale, "R2 data mode pins", {nand_ce_n, nand_cle, nand_ale}, 3'b000);
    wp = we_pulses;
    wr_data(1, 16'h5AC3);
    chk(we_pulses == wp + 2, "R5 two write cycles", we_pulses - wp, 2);
    chk(wait_cycles == 2 * (STROBE + 1), "R8 wait for two bytes", wait_cycles, 2 * (STROBE + 1));
    wr_data(1, 16'h0FF0);

    // R6 16-bit and 8-bit reads
    flash_src.push_back(8'h34); flash_src.push_back(8'h12);
    access(0, 3'd0, 1, 16'h0);
    chk(bus_rdata == 16'h1234, "R6 wide read order", bus_rdata, 16'h1234);
    chk(wait_cycles == 2 * (STROBE + 1), "R8 wait for wide read", wait_cycles, 2 * (STROBE + 1));
    flash_src.push_back(8'hC7);
    access(0, 3'd0, 0, 16'h0);
    chk(bus_rdata == 16'h00C7, "R6 narrow read", bus_rdata, 16'h00C7);

    // R2/R9 standby: no strobes, no wait, read returns 0
    access(1, 3'd4, 0, 16'h0000);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R2 standby pins", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    wp = we_pulses;
    access(1, 3'd0, 1, 16'hDEAD);
    chk(we_pulses == wp && wait_cycles == 0, "R9 standby write ignored", {we_pulses - wp, wait_cycles}, 0);
    wp = re_pulses;
    access(0, 3'd0, 1, 16'h0);
    chk(bus_rdata == 0 && re_pulses == wp, "R9 standby read", bus_rdata, 0);

    // R10 busy flag
    nand_rb = 0; repeat (3) @(negedge clk);
    rd_reg(3'd5, v); chk(v == 16'h0080, "R10 busy flag set", v, 16'h0080);

    // R12 enabled interrupt, R11 rising edge
    access(1, 3'd7, 0, 16'h0081);
    access(1, 3'd6, 0, 16'h000F);
    chk(!irq, "R12 irq low while busy", irq, 0);
    nand_rb = 1; repeat (5) @(negedge clk);
    chk(irq, "R12 irq on ready", irq, 1);
    rd_reg(3'd6, v); chk(v[0], "R11 ready request latched", v, 1);
    rd_reg(3'd5, v); chk(v == 0, "R10 busy flag clear", v, 0);

    // R13 clear
    access(1, 3'd6, 0, 16'h000F);
    rd_reg(3'd6, v); chk(v == 0, "R13 status cleared", v, 0);
    chk(!irq, "R13 irq dropped", irq, 0);

    // R11 falling edge does not set
    nand_rb = 0; repeat (5) @(negedge clk);
    rd_reg(3'd6, v); chk(v == 0, "R11 falling edge ignored", v, 0);

    // R12 masked
    access(1, 3'd7, 0, 16'h0000);
    nand_rb = 1; repeat (5) @(negedge clk);
    rd_reg(3'd6, v); chk(v[0], "R11 latched while masked", v, 1);
    chk(!irq, "R12 masked irq low", irq, 0);
    access(1, 3'd6, 0, 16'h000F);

    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule